// File: doc/BRIEF.md
# Synchronous serial controller

This block sits on a simple word-wide register bus and moves data words between a processor and one attached serial device. Software writes words into an eight-entry transmit queue and reads replies back from an eight-entry receive queue. A transfer engine takes the oldest transmit word, exchanges it for one reply word, and stores the reply. Bit-level serialisation is left to whatever sits behind the word exchange port. A loopback selection feeds each transmit word straight back into the receive queue instead.

Word width is chosen at run time by a 4-bit size field, and every word entering either queue is trimmed to that width. The engine never overruns the receive queue: it pauses while the queue is full and continues once software reads a word. Status bits report the fill state of both queues. One level interrupt reports half-level thresholds, gated by a mask register. A read-only identification window sits at the top of the address space.

Top module: `ssp_ctrl`

## Requirements
- R1: After reset both queues are empty, the interrupt mask (0x14) is zero, status (0x0C) reads 0x03, raw interrupt status (0x18) reads 0x08 and `irq` is low.
- R2: Bits 3:0 of control 0 (offset 0x00, read back in full) hold a value n. Each word written to the transmit queue and each word stored into the receive queue is ANDed with (2^(n+1))-1.
- R3: In control 1 (offset 0x04, bits 3:0 read back), bit 0 selects loopback and bit 1 enables transfers. While bit 1 is clear no word leaves the transmit queue.
- R4: The engine moves words while the transmit queue is non-empty and the receive queue holds fewer than 8 entries. With 8 received entries it stalls and keeps the transmit words, and it resumes after a data read.
- R5: The stored word is the transmit word in loopback. Otherwise it is the exchange response when `dev_present` is high, and zero when `dev_present` is low.
- R6: With an attached device and no loopback, the engine offers the oldest transmit word on `xchg_req_data` with `xchg_req_valid`. It keeps at most one word outstanding after `xchg_req_ready`. The word leaves the transmit queue and enters the receive queue only in the cycle `xchg_rsp_valid` is high.
- R7: Status (0x0C): bit 0 transmit empty, bit 1 transmit not full, bit 2 receive not empty, bit 3 receive full, bit 4 busy (transmit queue non-empty).
- R8: Raw status (0x18) bit 2 is set when the receive queue holds 4 or more words, and bit 3 when the transmit queue holds 4 or fewer. Mask (0x14) keeps bits 3:0. Masked status (0x1C) is mask AND raw, and `irq` is high when it is non-zero.
- R9: Reading data (0x08) returns and removes the oldest received word, in write order. An empty read returns zero and changes nothing, and a data write while the transmit queue holds 8 words is dropped.
- R10: Prescale (0x10) stores and returns the low 8 bits of the written value.
- R11: Reads at 0xFE0 to 0xFFC return one identification byte per word, in this order: 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R12: Undefined offsets, including 0x20 and 0x24, read as zero. Writes to status, the two interrupt status registers or undefined offsets change nothing, and every access completes in its own cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Level interrupt |
| dev_present | input | 1 | An external device answers exchanges |
| xchg_req_valid | output | 1 | Transmit word offered to the device |
| xchg_req_ready | input | 1 | Device accepts the offered word |
| xchg_req_data | output | 16 | Offered transmit word |
| xchg_rsp_valid | input | 1 | Device returns its reply word |
| xchg_rsp_data | input | 16 | Reply word |

## Verification
The assertions check on every cycle the rules that hold whatever the data: the receive queue is never pushed while full, and an engine that is switched off and idle makes no request. Loopback never reaches the device, only one exchange is ever outstanding, a word leaves only with a response, a full transmit queue stays full when it is written, and the receive-level interrupt is raised whenever it is enabled. Only the bench scenarios can show the data itself: masking to the chosen width, the order of words out of the queues, the zero word from an absent device, the stall releasing word by word as software reads, the status and interrupt values at each fill level, and the identification bytes.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  typedef enum logic {
    XF_IDLE = 1'b0,
    XF_WAIT = 1'b1
  } xfer_state_t;

  // Register word indices (byte offset / 4)
  localparam int OFS_CTRL0 = 0;
  localparam int OFS_CTRL1 = 1;
  localparam int OFS_DATA  = 2;
  localparam int OFS_STAT  = 3;
  localparam int OFS_PRESC = 4;
  localparam int OFS_MASK  = 5;
  localparam int OFS_RAW   = 6;
  localparam int OFS_MSK   = 7;

  // Status bit positions
  localparam int ST_TX_EMPTY = 0;
  localparam int ST_TX_NFULL = 1;
  localparam int ST_RX_NEMPT = 2;
  localparam int ST_RX_FULL  = 3;
  localparam int ST_BUSY     = 4;

  // Interrupt bit positions
  localparam int IRQ_RX_LVL = 2;
  localparam int IRQ_TX_LVL = 3;

  // Control 1 bit positions
  localparam int C1_LOOP = 0;
  localparam int C1_EN   = 1;

  // Width mask for a size field n: (2^(n+1))-1
  function automatic logic [31:0] size_mask(input logic [3:0] n);
    logic [32:0] full;
    full = (33'd1 << ({1'b0, n} + 5'd1)) - 33'd1;
    return full[31:0];
  endfunction

  // Identification window contents
  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: return 8'h22;
      3'd1: return 8'h10;
      3'd2: return 8'h04;
      3'd3: return 8'h00;
      3'd4: return 8'h0D;
      3'd5: return 8'hF0;
      3'd6: return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic             do_push, do_pop;

  assign full    = (count == FULL_CNT);
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ssp_xfer.sv
module ssp_xfer import ssp_pkg::*; #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              loopback,
  input  logic              dev_present,
  input  logic              tx_empty,
  input  logic              rx_full,
  input  logic [WORD_W-1:0] tx_head,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_data,
  output logic              req_valid,
  output logic [WORD_W-1:0] req_data,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_word,
  output logic              in_wait
);
  xfer_state_t state_q, state_d;
  logic go, direct;

  assign go       = en && !tx_empty && !rx_full;
  assign direct   = loopback || !dev_present;
  assign req_data = tx_head;
  assign in_wait  = (state_q == XF_WAIT);

  always_comb begin
    state_d   = state_q;
    req_valid = 1'b0;
    tx_pop    = 1'b0;
    rx_push   = 1'b0;
    rx_word   = '0;
    case (state_q)
      XF_IDLE: begin
        if (go) begin
          if (direct) begin
            tx_pop  = 1'b1;
            rx_push = 1'b1;
            rx_word = loopback ? tx_head : '0;
          end else begin
            req_valid = 1'b1;
            if (req_ready) state_d = XF_WAIT;
          end
        end
      end
      XF_WAIT: begin
        if (rsp_valid) begin
          tx_pop  = 1'b1;
          rx_push = 1'b1;
          rx_word = rsp_data;
          state_d = XF_IDLE;
        end
      end
      default: state_d = XF_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= XF_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/ssp_regs.sv
module ssp_regs import ssp_pkg::*; #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int WORD_W = 16,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [WORD_W-1:0] rx_dout,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic              tx_full,
  input  logic              tx_empty,
  input  logic              rx_full,
  input  logic              rx_empty,
  output logic [WORD_W-1:0] mask,
  output logic              en,
  output logic              loopback,
  output logic [3:0]        im,
  output logic              tx_push,
  output logic [WORD_W-1:0] tx_din,
  output logic              rx_pop,
  output logic              irq
);
  localparam int WI_W = ADDR_W - 2;
  localparam int HALF = DEPTH / 2;

  logic [WORD_W-1:0] ctrl0_q;
  logic [3:0]        ctrl1_q;
  logic [7:0]        presc_q;
  logic [3:0]        im_q;
  logic [WI_W-1:0]   widx;
  logic              is_id, wr_hit, rd_hit, hit_data;
  logic [4:0]        status;
  logic [3:0]        raw;
  logic [31:0]       mask_full;
  logic              unused_bits;

  assign widx     = addr[ADDR_W-1:2];
  assign is_id    = &addr[ADDR_W-1:5];
  assign wr_hit   = sel && wr;
  assign rd_hit   = sel && !wr;
  assign hit_data = (widx == WI_W'(OFS_DATA)) && !is_id;

  assign mask_full = size_mask(ctrl0_q[3:0]);
  assign mask      = mask_full[WORD_W-1:0];
  assign en        = ctrl1_q[C1_EN];
  assign loopback  = ctrl1_q[C1_LOOP];
  assign im        = im_q;

  assign tx_push = wr_hit && hit_data && !tx_full;
  assign tx_din  = wdata[WORD_W-1:0] & mask;
  assign rx_pop  = rd_hit && hit_data && !rx_empty;

  assign unused_bits = ^{wdata[DATA_W-1:WORD_W], addr[1:0], rx_full};

  always_comb begin
    status              = '0;
    status[ST_TX_EMPTY] = tx_empty;
    status[ST_TX_NFULL] = !tx_full;
    status[ST_RX_NEMPT] = !rx_empty;
    status[ST_RX_FULL]  = (int'(rx_count) == DEPTH);
    status[ST_BUSY]     = !tx_empty;
    raw                 = '0;
    raw[IRQ_RX_LVL]     = (int'(rx_count) >= HALF);
    raw[IRQ_TX_LVL]     = (int'(tx_count) <= HALF);
  end

  assign irq = |(raw & im_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl0_q <= '0;
      ctrl1_q <= '0;
      presc_q <= '0;
      im_q    <= '0;
    end else if (wr_hit && !is_id) begin
      case (widx)
        WI_W'(OFS_CTRL0): ctrl0_q <= wdata[WORD_W-1:0];
        WI_W'(OFS_CTRL1): ctrl1_q <= wdata[3:0];
        WI_W'(OFS_PRESC): presc_q <= wdata[7:0];
        WI_W'(OFS_MASK):  im_q    <= wdata[3:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (is_id) begin
      rdata = DATA_W'(id_byte(addr[4:2]));
    end else begin
      case (widx)
        WI_W'(OFS_CTRL0): rdata = DATA_W'(ctrl0_q);
        WI_W'(OFS_CTRL1): rdata = DATA_W'(ctrl1_q);
        WI_W'(OFS_DATA):  rdata = rx_empty ? '0 : DATA_W'(rx_dout);
        WI_W'(OFS_STAT):  rdata = DATA_W'(status);
        WI_W'(OFS_PRESC): rdata = DATA_W'(presc_q);
        WI_W'(OFS_MASK):  rdata = DATA_W'(im_q);
        WI_W'(OFS_RAW):   rdata = DATA_W'(raw);
        WI_W'(OFS_MSK):   rdata = DATA_W'(raw & im_q);
        default:          rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl import ssp_pkg::*; #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int WORD_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic              dev_present,
  output logic              xchg_req_valid,
  input  logic              xchg_req_ready,
  output logic [WORD_W-1:0] xchg_req_data,
  input  logic              xchg_rsp_valid,
  input  logic [WORD_W-1:0] xchg_rsp_data
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]  tx_count, rx_count;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              tx_push, tx_pop, rx_push, rx_pop;
  logic [WORD_W-1:0] tx_din, tx_head, rx_din, rx_dout, rx_word, mask;
  logic              en, loopback, in_wait;
  logic [3:0]        im;

  assign rx_din = rx_word & mask;

  ssp_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_W(WORD_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .rx_dout(rx_dout),
    .tx_count(tx_count), .rx_count(rx_count), .tx_full(tx_full),
    .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
    .mask(mask), .en(en), .loopback(loopback), .im(im), .tx_push(tx_push),
    .tx_din(tx_din), .rx_pop(rx_pop), .irq(irq)
  );

  ssp_fifo #(.W(WORD_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .din(tx_din), .pop(tx_pop),
    .dout(tx_head), .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  ssp_fifo #(.W(WORD_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_din), .pop(rx_pop),
    .dout(rx_dout), .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  ssp_xfer #(.WORD_W(WORD_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .en(en), .loopback(loopback),
    .dev_present(dev_present), .tx_empty(tx_empty), .rx_full(rx_full),
    .tx_head(tx_head), .req_ready(xchg_req_ready), .rsp_valid(xchg_rsp_valid),
    .rsp_data(xchg_rsp_data), .req_valid(xchg_req_valid),
    .req_data(xchg_req_data), .tx_pop(tx_pop), .rx_push(rx_push),
    .rx_word(rx_word), .in_wait(in_wait)
  );
endmodule

// File: rtl/ssp_ctrl_chk.sv
module ssp_ctrl_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             loopback,
  input logic             req_valid,
  input logic             rsp_valid,
  input logic             in_wait,
  input logic             tx_pop,
  input logic             tx_full,
  input logic             rx_push,
  input logic             rx_full,
  input logic [CNT_W-1:0] rx_count,
  input logic [3:0]       im,
  input logic             irq
);
  localparam int HALF = DEPTH / 2;

  a_r4_no_rx_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !rx_push);

  a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !in_wait) |-> (!req_valid && !tx_pop));

  a_r5_loop_stays_local: assert property (@(posedge clk) disable iff (!rst_n)
    loopback |-> !req_valid);

  a_r6_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> !req_valid);

  a_r6_pop_needs_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && in_wait) |-> rsp_valid);

  a_r9_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && !tx_pop) |=> tx_full);

  a_r8_rx_level_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(rx_count) >= HALF) && im[2]) |-> irq);
endmodule

bind ssp_ctrl ssp_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .loopback(loopback),
  .req_valid(xchg_req_valid), .rsp_valid(xchg_rsp_valid), .in_wait(in_wait),
  .tx_pop(tx_pop), .tx_full(tx_full), .rx_push(rx_push), .rx_full(rx_full),
  .rx_count(rx_count), .im(im), .irq(irq)
);

// File: tb/ssp_ctrl_test.sv
`timescale 1ns/1ps
module ssp_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic        dev_present = 1'b0;
  logic        xchg_req_valid;
  logic        xchg_req_ready = 1'b1;
  logic [15:0] xchg_req_data;
  logic        xchg_rsp_valid;
  logic [15:0] xchg_rsp_data;

  int nvec = 0, nfail = 0;
  int resp_delay = 2;
  int busy = 0, hs = 0;
  logic [15:0] pend;
  bit done = 0;

  always #5 clk = ~clk;

  ssp_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .dev_present(dev_present), .xchg_req_valid(xchg_req_valid),
    .xchg_req_ready(xchg_req_ready), .xchg_req_data(xchg_req_data),
    .xchg_rsp_valid(xchg_rsp_valid), .xchg_rsp_data(xchg_rsp_data)
  );

  // Device model: reply = request XOR A5A5 after resp_delay cycles
  initial begin
    xchg_rsp_valid = 1'b0;
    xchg_rsp_data  = '0;
    forever begin
      @(negedge clk);
      xchg_rsp_valid = 1'b0;
      if (busy != 0) begin
        busy--;
        if (busy == 0) begin
          xchg_rsp_valid = 1'b1;
          xchg_rsp_data  = pend;
        end
      end else if (xchg_req_valid && xchg_req_ready) begin
        pend = xchg_req_data ^ 16'hA5A5;
        busy = resp_delay;
        hs++;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    check(tag, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // op: 0 write, 1 read and compare, 2 idle
  localparam int NV = 30;
  localparam logic [77:0] VEC [NV] = '{
    {2'd0, 12'h000, 32'h7,    32'h0},   // R2 8-bit words
    {2'd0, 12'h004, 32'h3,    32'h0},   // R3 enable + loopback
    {2'd1, 12'h004, 32'h0,    32'h3},   // R3 readback
    {2'd0, 12'h008, 32'h1234, 32'h0},
    {2'd0, 12'h008, 32'h00AB, 32'h0},
    {2'd2, 12'h000, 32'h0,    32'h0},
    {2'd1, 12'h00C, 32'h0,    32'h7},   // R7 tx empty, rx not empty
    {2'd1, 12'h008, 32'h0,    32'h34},  // R2 masked, R5 loopback
    {2'd1, 12'h008, 32'h0,    32'hAB},  // R9 order
    {2'd1, 12'h008, 32'h0,    32'h0},   // R9 empty read
    {2'd1, 12'h00C, 32'h0,    32'h3},   // R7
    {2'd0, 12'h000, 32'h3,    32'h0},   // R2 4-bit words
    {2'd0, 12'h008, 32'hFF,   32'h0},
    {2'd2, 12'h000, 32'h0,    32'h0},
    {2'd1, 12'h008, 32'h0,    32'hF},   // R2
    {2'd0, 12'h010, 32'h1FF,  32'h0},
    {2'd1, 12'h010, 32'h0,    32'hFF},  // R10
    {2'd0, 12'h014, 32'hFF,   32'h0},
    {2'd1, 12'h014, 32'h0,    32'hF},   // R8 mask width
    {2'd1, 12'h018, 32'h0,    32'h8},   // R8 raw
    {2'd1, 12'h01C, 32'h0,    32'h8},   // R8 masked
    {2'd1, 12'h020, 32'h0,    32'h0},   // R12
    {2'd1, 12'h024, 32'h0,    32'h0},   // R12
    {2'd0, 12'h00C, 32'hFF,   32'h0},   // R12 write to status
    {2'd1, 12'h00C, 32'h0,    32'h3},   // R12
    {2'd1, 12'hFE0, 32'h0,    32'h22},  // R11
    {2'd1, 12'hFF0, 32'h0,    32'h0D},  // R11
    {2'd1, 12'hFFC, 32'h0,    32'hB1},  // R11
    {2'd0, 12'h014, 32'h0,    32'h0},
    {2'd1, 12'h000, 32'h0,    32'h3}    // R2 control 0 readback
  };

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd_chk("R1 status", 12'h00C, 32'h03);
    rd_chk("R1 raw", 12'h018, 32'h08);
    rd_chk("R1 mask", 12'h014, 32'h00);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][77:76])
        2'd0: bus_write(VEC[i][75:64], VEC[i][63:32]);
        2'd1: begin
          bus_read(VEC[i][75:64], v);
          check($sformatf("vector %0d", i), v, VEC[i][31:0]);
        end
        default: idle(4);
      endcase
    end

    // R3: disabled port keeps words queued
    bus_write(12'h000, 32'hF);
    bus_write(12'h004, 32'h1);
    bus_write(12'h008, 32'h1111);
    bus_write(12'h008, 32'h2222);
    bus_write(12'h008, 32'h3333);
    idle(4);
    rd_chk("R3 status off", 12'h00C, 32'h12);
    rd_chk("R8 raw tx level", 12'h018, 32'h08);
    bus_write(12'h004, 32'h3);
    idle(4);
    rd_chk("R3 status on", 12'h00C, 32'h07);
    rd_chk("R3 word0", 12'h008, 32'h1111);
    rd_chk("R3 word1", 12'h008, 32'h2222);
    rd_chk("R3 word2", 12'h008, 32'h3333);

    // R4 stall, R9 drop when full
    for (int i = 0; i < 16; i++) bus_write(12'h008, 32'h1000 + i);
    bus_write(12'h008, 32'hDEAD);
    idle(6);
    rd_chk("R4 stalled status", 12'h00C, 32'h1C);
    rd_chk("R8 raw rx level", 12'h018, 32'h04);
    bus_write(12'h014, 32'h4);
    check("R8 irq rx", {31'b0, irq}, 32'h1);
    rd_chk("R8 masked", 12'h01C, 32'h04);
    for (int i = 0; i < 16; i++) begin
      rd_chk($sformatf("R4 drain %0d", i), 12'h008, 32'h1000 + i);
      idle(1);
    end
    rd_chk("R9 dropped write", 12'h008, 32'h0);
    rd_chk("R4 status drained", 12'h00C, 32'h03);
    check("R8 irq low", {31'b0, irq}, 32'h0);
    bus_write(12'h014, 32'h0);

    // R5 / R6 external exchange
    bus_write(12'h000, 32'h7);
    bus_write(12'h004, 32'h2);
    dev_present = 1'b1;
    resp_delay  = 6;
    hs = 0;
    bus_write(12'h008, 32'h11);
    idle(1);
    rd_chk("R6 pending word", 12'h00C, 32'h12);
    check("R6 one request", hs, 1);
    idle(12);
    rd_chk("R6 after response", 12'h00C, 32'h07);
    rd_chk("R5 reply masked", 12'h008, 32'hB4);
    resp_delay = 2;
    bus_write(12'h008, 32'h22);
    bus_write(12'h008, 32'h33);
    idle(16);
    rd_chk("R5 reply 2", 12'h008, 32'h87);
    rd_chk("R5 reply 3", 12'h008, 32'h96);
    check("R6 request count", hs, 3);

    // R5 no device: zero word
    dev_present = 1'b0;
    bus_write(12'h008, 32'h5A);
    idle(4);
    rd_chk("R5 nodev status", 12'h00C, 32'h07);
    rd_chk("R5 nodev word", 12'h008, 32'h0);
    rd_chk("R5 nodev empty", 12'h00C, 32'h03);

    // R8 transmit threshold
    bus_write(12'h014, 32'h8);
    check("R8 irq tx", {31'b0, irq}, 32'h1);
    bus_write(12'h004, 32'h1);
    for (int i = 0; i < 5; i++) bus_write(12'h008, 32'h40 + i);
    rd_chk("R8 raw tx 5", 12'h018, 32'h00);
    check("R8 irq off", {31'b0, irq}, 32'h0);
    bus_write(12'h004, 32'h3);
    idle(8);
    rd_chk("R8 raw rx 5", 12'h018, 32'h0C);
    rd_chk("R8 masked tx", 12'h01C, 32'h08);
    for (int i = 0; i < 5; i++) rd_chk("R9 drain", 12'h008, 32'h40 + i);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule